// File: doc/BRIEF.md
# Sparse Carry-Tree Binary Adder

This block adds two unsigned operands and a carry-in in a single combinational path. It returns the sum and the carry-out. Every bit first forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). Each fixed-width slice of the operands is reduced to one group generate/propagate pair by a balanced tree of two-input merge cells. A chain across the slices then forms the carry only at slice boundaries. That chain alternates three-input merges, which span two slices at once, with two-input merges for the odd positions. The carry-in is treated as a generate term sitting just below bit 0.

Each slice's final sum is formed by a local ripple adder, chosen by parameter in one of two ways. In select mode, the slice holds two ripple results, one for an incoming carry of 0 and one for 1, and the boundary carry picks between them. In ripple mode, the boundary carry is fed straight into a single ripple chain. The operand width is intended to be 16 or 32, and the slice width 4, 8 or 16. Elaboration stops if the width is not a whole multiple of the slice width, or if the slice width is not a power of two. The block has no clock and no handshake: outputs follow the inputs.

Top module: `ssta_adder`

## Requirements
- R1: For any operands and either carry-in value, {cout, sum} equals a + b + cin computed at WIDTH+1 bits.
- R2: The carry formed at each slice boundary k*SEC equals the carry out of the low k*SEC bits of a + b + cin. A carry produced in a lower slice therefore appears as bit k*SEC of the sum.
- R3: When every bit propagates (a ^ b all ones), cout equals cin. The sum is all ones when cin is 0 and all zeros when cin is 1.
- R4: With both operands zero, sum equals cin in bit 0 with zeros above, and cout is 0.
- R5: All-ones plus one with cin 0 gives a zero sum and cout 1.
- R6: Every legal combination of WIDTH (16, 32), SEC (4, 8, 16) and final-stage mode (CSEL 1 select, 0 ripple) gives the same result for the same inputs.
- R7: Two operands that both have only the top bit set give a zero sum and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
The assertions are evaluated each time the combinational inputs settle. They assume that a, b and cin hold only known 0/1 values, because an unknown bit would feed the reference addition and the conditions of the pattern checks. The bench drives every input from a task at a clock edge with fully specified values, and samples half a period later. All twelve parameter variants are fed from one shared stimulus, with the 16-bit ones taking the low half.

// File: rtl/ssta_pkg.sv
package ssta_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Two adjacent groups, hi above lo.
  function automatic gp_t merge2(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Three adjacent groups merged in one level.
  function automatic gp_t merge3(gp_t hi, gp_t mid, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & mid.g) | (hi.p & mid.p & lo.g);
    r.p = hi.p & mid.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/ssta_sec_tree.sv
module ssta_sec_tree
  import ssta_pkg::*;
#(
  parameter int SEC = 8
) (
  input  logic [SEC-1:0] g_in,
  input  logic [SEC-1:0] p_in,
  output gp_t            grp
);
  localparam int LEVELS = $clog2(SEC);

  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int CNT = SEC >> l;
    gp_t [CNT-1:0] n;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_bit
        assign n[j] = gp_t'({g_in[j], p_in[j]});
      end
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_pair
        assign n[j] = merge2(lvl[l-1].n[2*j+1], lvl[l-1].n[2*j]);
      end
    end
  end

  assign grp = lvl[LEVELS].n[0];
endmodule

// File: rtl/ssta_ripple.sv
module ssta_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] c;

  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = a[i] ^ b[i] ^ c[i];
    if (i < W - 1) begin : g_chain
      assign c[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & c[i]);
    end
  end
endmodule

// File: rtl/ssta_section.sv
module ssta_section #(
  parameter int SEC  = 8,
  parameter bit CSEL = 1'b1
) (
  input  logic [SEC-1:0] a,
  input  logic [SEC-1:0] b,
  input  logic           cin,
  output logic [SEC-1:0] sum
);
  if (CSEL) begin : g_select
    logic [SEC-1:0] s_lo, s_hi;
    ssta_ripple #(.W(SEC)) u_zero (.a(a), .b(b), .cin(1'b0), .sum(s_lo));
    ssta_ripple #(.W(SEC)) u_one  (.a(a), .b(b), .cin(1'b1), .sum(s_hi));
    assign sum = cin ? s_hi : s_lo;
  end else begin : g_plain
    ssta_ripple #(.W(SEC)) u_chain (.a(a), .b(b), .cin(cin), .sum(sum));
  end
endmodule

// File: rtl/ssta_adder.sv
module ssta_adder
  import ssta_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SEC   = 8,
  parameter bit CSEL  = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSEC = WIDTH / SEC;

  if ((WIDTH % SEC) != 0) begin : g_bad_ratio
    $error("ssta_adder: WIDTH must be a multiple of SEC");
  end
  if (SEC < 2 || (SEC & (SEC - 1)) != 0) begin : g_bad_sec
    $error("ssta_adder: SEC must be a power of two of at least 2");
  end

  logic [WIDTH-1:0] bit_g, bit_p;
  assign bit_g = a & b;
  assign bit_p = a ^ b;

  gp_t [NSEC-1:0] sgrp;
  logic [NSEC:0]  bcarry;

  for (genvar k = 0; k < NSEC; k++) begin : g_tree
    ssta_sec_tree #(.SEC(SEC)) u_tree (
      .g_in (bit_g[k*SEC +: SEC]),
      .p_in (bit_p[k*SEC +: SEC]),
      .grp  (sgrp[k])
    );
  end

  // Boundary chain: even positions jump two slices with a 3-input merge.
  assign bcarry[0] = cin;
  for (genvar k = 1; k <= NSEC; k++) begin : g_bnd
    if (k >= 2 && (k % 2) == 0) begin : g_m3
      gp_t r3;
      assign r3 = merge3(sgrp[k-1], sgrp[k-2], gp_t'({bcarry[k-2], 1'b0}));
      assign bcarry[k] = r3.g;
    end else begin : g_m2
      gp_t r2;
      assign r2 = merge2(sgrp[k-1], gp_t'({bcarry[k-1], 1'b0}));
      assign bcarry[k] = r2.g;
    end
  end

  for (genvar k = 0; k < NSEC; k++) begin : g_fin
    ssta_section #(.SEC(SEC), .CSEL(CSEL)) u_sec (
      .a   (a[k*SEC +: SEC]),
      .b   (b[k*SEC +: SEC]),
      .cin (bcarry[k]),
      .sum (sum[k*SEC +: SEC])
    );
  end

  assign cout = bcarry[NSEC];
endmodule

// File: rtl/ssta_checker.sv
module ssta_checker #(
  parameter int WIDTH = 32,
  parameter int SEC   = 8
) (
  input logic [WIDTH-1:0]     a,
  input logic [WIDTH-1:0]     b,
  input logic                 cin,
  input logic [WIDTH-1:0]     sum,
  input logic                 cout,
  input logic [WIDTH/SEC:0]   bcarry
);
  localparam int NSEC = WIDTH / SEC;

  logic [WIDTH:0] full_ref;
  assign full_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    AST_SUM_MATCH: assert ({cout, sum} == full_ref) else $error("sum mismatch"); // R1
    if (&(a ^ b)) begin
      AST_FULL_PROPAGATE: assert (cout == cin && sum == {WIDTH{~cin}}) else $error("propagate"); // R3
    end
    if (a == '0 && b == '0) begin
      AST_ZERO_OPERANDS: assert (sum == WIDTH'(cin) && !cout) else $error("zero"); // R4
    end
    if (&a && b == WIDTH'(1) && !cin) begin
      AST_WRAP_AROUND: assert (sum == '0 && cout) else $error("wrap"); // R5
    end
  end

  always_comb begin
    for (int k = 1; k <= NSEC; k++) begin
      logic [WIDTH:0] mask, low;
      mask = ((WIDTH+1)'(1) << (k*SEC)) - (WIDTH+1)'(1);
      low  = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, cin};
      AST_BOUNDARY_CARRY: assert (bcarry[k] == low[k*SEC]) else $error("boundary"); // R2
    end
  end
endmodule

bind ssta_adder ssta_checker #(.WIDTH(WIDTH), .SEC(SEC)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .bcarry(bcarry)
);

// File: tb/ssta_adder_bench.sv
module ssta_adder_bench;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic        done = 1'b0;
  int checks = 0;
  int errors = 0;

  logic [31:0] m_sum;
  logic        m_cout;
  ssta_adder #(.WIDTH(32), .SEC(8), .CSEL(1'b1)) u_ssta_adder (
    .a(a), .b(b), .cin(cin), .sum(m_sum), .cout(m_cout)
  );

  logic [31:0] vsum  [NV];
  logic        vcout [NV];

  function automatic int vwidth(int i);
    return (i < 6) ? 16 : 32;
  endfunction

  for (genvar i = 0; i < NV; i++) begin : g_var
    localparam int  W  = (i < 6) ? 16 : 32;
    localparam int  S  = 4 << ((i / 2) % 3);
    localparam bit  CS = (i % 2) == 0;
    logic [W-1:0] s;
    ssta_adder #(.WIDTH(W), .SEC(S), .CSEL(CS)) u_var (
      .a(a[W-1:0]), .b(b[W-1:0]), .cin(cin), .sum(s), .cout(vcout[i])
    );
    assign vsum[i] = 32'(s);
  end

  task automatic drive(input logic [31:0] na, input logic [31:0] nb, input logic nc);
    @(posedge clk);
    a = na; b = nb; cin = nc;
    @(negedge clk);
  endtask

  // Compare main instance and every variant against a reference sum.
  task automatic check_all(input string req);
    logic [32:0] r;
    r = {1'b0, a} + {1'b0, b} + {32'b0, cin};
    checks++;
    if ({m_cout, m_sum} !== r) begin
      errors++;
      $display("FAIL %s main got %h_%h exp %h_%h", req, m_cout, m_sum, r[32], r[31:0]);
    end
    for (int i = 0; i < NV; i++) begin
      logic [32:0] e;
      if (vwidth(i) == 16) begin
        logic [16:0] h;
        h = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'b0, cin};
        e = {h[16], 16'b0, h[15:0]};
      end else begin
        e = r;
      end
      checks++;
      if ({vcout[i], vsum[i]} !== e) begin
        errors++;
        $display("FAIL %s variant %0d got %h_%h exp %h_%h", req, i, vcout[i], vsum[i], e[32], e[31:0]);
      end
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    checks++;
    if (m_sum !== 32'h0 || m_cout !== 1'b0) begin
      errors++;
      $display("FAIL R4 idle got %h_%h exp 0_00000000", m_cout, m_sum);
    end
  endtask

  task automatic t_zero;  // R4
    drive('0, '0, 1'b0); check_all("R4");
    drive('0, '0, 1'b1); check_all("R4");
    checks++;
    if (m_sum !== 32'h1 || m_cout !== 1'b0) begin
      errors++;
      $display("FAIL R4 got %h_%h exp 0_00000001", m_cout, m_sum);
    end
  endtask

  task automatic t_wrap;  // R5
    drive(32'hFFFF_FFFF, 32'h1, 1'b0); check_all("R5");
    checks++;
    if (m_sum !== 32'h0 || m_cout !== 1'b1) begin
      errors++;
      $display("FAIL R5 got %h_%h exp 1_00000000", m_cout, m_sum);
    end
    drive(32'hFFFF_FFFF, 32'h0, 1'b1); check_all("R5");
  endtask

  task automatic t_alternate;  // R3
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0); check_all("R3");
    checks++;
    if (m_sum !== 32'hFFFF_FFFF || m_cout !== 1'b0) begin
      errors++;
      $display("FAIL R3 got %h_%h exp 0_ffffffff", m_cout, m_sum);
    end
    drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b1); check_all("R3");
    checks++;
    if (m_sum !== 32'h0 || m_cout !== 1'b1) begin
      errors++;
      $display("FAIL R3 got %h_%h exp 1_00000000", m_cout, m_sum);
    end
  endtask

  task automatic t_boundary;  // R2
    for (int k = 4; k <= 28; k += 4) begin
      logic [31:0] lo;
      lo = (32'h1 << k) - 32'h1;
      drive(lo, 32'h1, 1'b0); check_all("R2");
      checks++;
      if (m_sum !== (32'h1 << k)) begin
        errors++;
        $display("FAIL R2 got %h exp %h", m_sum, 32'h1 << k);
      end
      drive(lo, 32'h0, 1'b1); check_all("R2");
    end
  endtask

  task automatic t_top_bit;  // R7
    drive(32'h8000_0000, 32'h8000_0000, 1'b0); check_all("R7");
    checks++;
    if (m_sum !== 32'h0 || m_cout !== 1'b1) begin
      errors++;
      $display("FAIL R7 got %h_%h exp 1_00000000", m_cout, m_sum);
    end
    drive(32'h0000_8000, 32'h0000_8000, 1'b0); check_all("R7");
    checks++;
    if (vsum[0] !== 32'h0 || vcout[0] !== 1'b1) begin
      errors++;
      $display("FAIL R7 16b got %h_%h exp 1_00000000", vcout[0], vsum[0]);
    end
  endtask

  task automatic t_variants;  // R6: select and ripple variants agree pairwise
    for (int n = 0; n < 40; n++) begin
      drive($urandom, $urandom, n[0]);
      for (int i = 0; i < NV; i += 2) begin
        checks++;
        if (vsum[i] !== vsum[i+1] || vcout[i] !== vcout[i+1]) begin
          errors++;
          $display("FAIL R6 pair %0d got %h_%h exp %h_%h", i, vcout[i+1], vsum[i+1], vcout[i], vsum[i]);
        end
      end
    end
  endtask

  task automatic t_random;  // R1
    for (int n = 0; n < 400; n++) begin
      drive($urandom, $urandom, n[1]);
      check_all("R1");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_zero();
    t_wrap();
    t_alternate();
    t_boundary();
    t_top_bit();
    t_variants();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule